// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller

This block manages a small volatile word array and the nonvolatile shadow array behind it. Software-style command strobes set and clear a write-enable latch, start a store (volatile to shadow) or a recall (shadow to volatile), and arm an automatic store on supply loss. An active-low hardware recall pin also starts a recall. A comparator flag reports a low supply. Store and recall are timed by cycle-count parameters. Each copy moves the whole array in one clock at the end of its timed window.

A store is accepted only when two latches are set. The first is the write-enable latch. The second is a previous-recall latch, which only a deliberate recall sets. Power-on reset runs an automatic recall that leaves the previous-recall latch clear. A finished store clears write enable. While any copy is in progress, `busy` is high and the block ignores every command, recall request and host write.

Host writes use a valid/ready port. `wr_ready` is low while `busy` is high, and the host must then hold `wr_valid`, `wr_addr` and `wr_data` steady. A beat accepted while write enable is clear completes the handshake, but its data is dropped. Reads are combinational through `rd_addr`. The supply-fail output is a pull-down enable for a shared open-drain line.

Top module: `nvsr_ctrl`

## Requirements
- R1: After power-on reset is released, `busy` stays high for exactly RECALL_CYCLES clock cycles. After that, the write-enable, previous-recall and autostore latches (`wel`, `prl`, `as_en`) all read 0.
- R2: While idle, `cmd_wren` sets `wel` and `cmd_wrds` clears it. When both arrive in the same cycle, the clear wins.
- R3: `wr_ready` equals not `busy`. An accepted beat writes `wr_data` to word `wr_addr` only if `wel` is 1. Otherwise the beat is dropped and that word keeps its value.
- R4: While idle, a `cmd_recall` pulse or a high-to-low change of `recall_pin_n` starts a recall. `busy` is then high for RECALL_CYCLES cycles. At the end the whole shadow is copied into the volatile array and `prl` becomes 1. Holding the pin low starts only one recall.
- R5: A store request is ignored, and `busy` stays low, unless both `wel` and `prl` are 1.
- R6: An accepted store holds `busy` high for STORE_CYCLES cycles. At the end it copies the whole volatile array into the shadow and clears `wel`.
- R7: While `busy` is high, these have no effect: write-enable set and clear, autostore enable, store and recall commands, recall pin edges and host writes.
- R8: While idle, `cmd_auto_en` sets `as_en`. With `as_en`, `wel` and `prl` all 1, a high `supply_low` starts a store, which then behaves as in R6.
- R9: `fail_pd` (1 = pull the shared line low) equals `supply_low` delayed by one clock, whatever the state of `as_en`.
- R10: Reset clears no shadow data. The recall after reset restores the last stored words and leaves `prl` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_wren | input | 1 | Set write-enable strobe |
| cmd_wrds | input | 1 | Clear write-enable strobe |
| cmd_store | input | 1 | Store request strobe |
| cmd_recall | input | 1 | Recall request strobe |
| cmd_auto_en | input | 1 | Arm automatic store strobe |
| recall_pin_n | input | 1 | Active-low hardware recall, falling-edge triggered |
| supply_low | input | 1 | Low-supply comparator flag |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Host write beat accepted this cycle |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 16 | Volatile word at rd_addr (combinational) |
| busy | output | 1 | Store or recall in progress |
| wel | output | 1 | Write-enable latch |
| prl | output | 1 | Previous-recall latch |
| as_en | output | 1 | Autostore-enable latch |
| fail_pd | output | 1 | Open-drain supply-fail pull-down enable |

## Verification
The assertions assume that `supply_low` is low while reset is asserted. They also assume that every command is a clean synchronous strobe with no X value once reset is released. The bench meets both assumptions: it drives every input from a negedge, holds the strobes low during reset, and raises `supply_low` only in idle phases. The store-rejection property assumes the recall pin is high in that cycle. The bench returns the pin high before it issues any rejected store.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STORE  = 2'd1,
    PH_RECALL = 2'd2
  } phase_t;
endpackage

// File: rtl/nvsr_latches.sv
module nvsr_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic cmd_wren,
  input  logic cmd_wrds,
  input  logic cmd_auto_en,
  input  logic store_done,
  input  logic recall_set,
  output logic wel,
  output logic prl,
  output logic as_en
);
  // write enable: completion of a store clears it; commands only act when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (store_done) begin
      wel <= 1'b0;
    end else if (!busy) begin
      if (cmd_wrds)      wel <= 1'b0;
      else if (cmd_wren) wel <= 1'b1;
    end
  end

  // previous recall: only a deliberate recall sets it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prl <= 1'b0;
    else if (recall_set) prl <= 1'b1;
  end

  // autostore arm: set by command, cleared only by power-on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     as_en <= 1'b0;
    else if (!busy && cmd_auto_en)  as_en <= 1'b1;
  end
endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq
  import nvsr_pkg::*;
#(
  parameter int STORE_CYCLES  = 625000,
  parameter int RECALL_CYCLES = 250
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   store_req,
  input  logic   recall_req,
  output phase_t phase,
  output logic   busy,
  output logic   store_done,
  output logic   recall_done,
  output logic   recall_set
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             pwrup;
  logic             last;

  assign last        = (cnt == '0);
  assign busy        = (phase != PH_IDLE);
  assign store_done  = (phase == PH_STORE)  && last;
  assign recall_done = (phase == PH_RECALL) && last;
  assign recall_set  = recall_done && !pwrup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RECALL;
      cnt   <= CNT_W'(RECALL_CYCLES - 1);
      pwrup <= 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (store_req) begin
            phase <= PH_STORE;
            cnt   <= CNT_W'(STORE_CYCLES - 1);
          end else if (recall_req) begin
            phase <= PH_RECALL;
            cnt   <= CNT_W'(RECALL_CYCLES - 1);
            pwrup <= 1'b0;
          end
        end
        default: begin
          if (last) phase <= PH_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nvsr_banks.sv
module nvsr_banks #(
  parameter int WORDS = 16,
  parameter int WIDTH = 16,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              do_store,
  input  logic              do_recall,
  output logic [WIDTH-1:0]  rd_data
);
  logic [WIDTH-1:0] vol [WORDS];
  logic [WIDTH-1:0] nv  [WORDS];

  // no reset on either array: volatile content is undefined at power-up,
  // nonvolatile content must survive it
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (do_recall)
        vol[w] <= nv[w];
      else if (wr_en && (wr_addr == ADDR_W'(w)))
        vol[w] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (do_store) nv[w] <= vol[w];
    end
  end

  assign rd_data = vol[rd_addr];
endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl #(
  parameter int WORDS         = 16,
  parameter int WIDTH         = 16,
  parameter int STORE_CYCLES  = 625000,
  parameter int RECALL_CYCLES = 250,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrds,
  input  logic              cmd_store,
  input  logic              cmd_recall,
  input  logic              cmd_auto_en,
  input  logic              recall_pin_n,
  input  logic              supply_low,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              busy,
  output logic              wel,
  output logic              prl,
  output logic              as_en,
  output logic              fail_pd
);
  import nvsr_pkg::*;

  phase_t phase;
  logic   store_done, recall_done, recall_set;
  logic   pin_q, pin_fall;
  logic   store_req, recall_req;
  logic   storing, recalling;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b1;
      fail_pd <= 1'b0;
    end else begin
      pin_q   <= recall_pin_n;
      fail_pd <= supply_low;
    end
  end

  assign pin_fall   = pin_q && !recall_pin_n;
  assign store_req  = !busy && wel && prl && (cmd_store || (as_en && supply_low));
  assign recall_req = !busy && (cmd_recall || pin_fall);
  assign wr_ready   = !busy;
  assign storing    = (phase == PH_STORE);
  assign recalling  = (phase == PH_RECALL);

  nvsr_seq #(
    .STORE_CYCLES (STORE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_req  (store_req),
    .recall_req (recall_req),
    .phase      (phase),
    .busy       (busy),
    .store_done (store_done),
    .recall_done(recall_done),
    .recall_set (recall_set)
  );

  nvsr_latches u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cmd_wren   (cmd_wren),
    .cmd_wrds   (cmd_wrds),
    .cmd_auto_en(cmd_auto_en),
    .store_done (store_done),
    .recall_set (recall_set),
    .wel        (wel),
    .prl        (prl),
    .as_en      (as_en)
  );

  nvsr_banks #(
    .WORDS(WORDS),
    .WIDTH(WIDTH)
  ) u_banks (
    .clk      (clk),
    .wr_en    (wr_valid && wr_ready && wel),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .do_store (store_done),
    .do_recall(recall_done),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/nvsr_ctrl_chk.sv
module nvsr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic storing,
  input logic recalling,
  input logic wel,
  input logic prl,
  input logic as_en,
  input logic cmd_store,
  input logic cmd_recall,
  input logic cmd_wrds,
  input logic recall_pin_n,
  input logic supply_low,
  input logic fail_pd
);
  // R2
  wrds_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wrds) |=> !wel);

  // R5
  guarded_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_store && !(wel && prl) && !cmd_recall && recall_pin_n) |=> !busy);

  // R6
  store_drops_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(storing) |-> !wel);

  // R4
  prl_from_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prl) |-> $past(recalling));

  // R7
  busy_wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel) |=> !wel);

  // R7
  busy_as_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !as_en) |=> !as_en);

  // R9
  fail_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fail_pd == $past(supply_low)));
endmodule

bind nvsr_ctrl nvsr_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .storing     (storing),
  .recalling   (recalling),
  .wel         (wel),
  .prl         (prl),
  .as_en       (as_en),
  .cmd_store   (cmd_store),
  .cmd_recall  (cmd_recall),
  .cmd_wrds    (cmd_wrds),
  .recall_pin_n(recall_pin_n),
  .supply_low  (supply_low),
  .fail_pd     (fail_pd)
);

// File: tb/nvsr_ctrl_bench.sv
module nvsr_ctrl_bench;
  localparam int WORDS = 16;
  localparam int WIDTH = 16;
  localparam int AW    = 4;
  localparam int ST    = 20;
  localparam int RC    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrds = 0, cmd_store = 0, cmd_recall = 0, cmd_auto_en = 0;
  logic recall_pin_n = 1, supply_low = 0, wr_valid = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic wr_ready, busy, wel, prl, as_en, fail_pd;
  logic [WIDTH-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nvsr_ctrl #(
    .WORDS(WORDS), .WIDTH(WIDTH), .STORE_CYCLES(ST), .RECALL_CYCLES(RC)
  ) u_nvsr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrds(cmd_wrds),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall), .cmd_auto_en(cmd_auto_en),
    .recall_pin_n(recall_pin_n), .supply_low(supply_low), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .wel(wel), .prl(prl), .as_en(as_en),
    .fail_pd(fail_pd)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected read words
  typedef struct { logic [AW-1:0] addr; logic [WIDTH-1:0] data; string req; } rd_item_t;
  rd_item_t sb[$];

  task automatic expect_word(input int a, input logic [WIDTH-1:0] d, input string req);
    rd_item_t it;
    it.addr = AW'(a); it.data = d; it.req = req;
    sb.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        rd_item_t it;
        it = sb.pop_front();
        rd_addr = it.addr;
        #1;
        check(rd_data === it.data, it.req, rd_data, it.data);
      end
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [WIDTH-1:0] pat(input int sel, input int i);
    return WIDTH'(16'h1357 * (sel + 1)) ^ WIDTH'(i * 16'h0f0b);
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic count_busy(input int exp, input string req);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == exp, req, n, exp);
  endtask

  task automatic stay_idle(input int cyc, input string req);
    bit seen = 0;
    for (int k = 0; k < cyc; k++) begin @(negedge clk); if (busy) seen = 1; end
    check(!seen, req, seen, 0);
  endtask

  task automatic write_word(input int a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic fill(input int sel);
    for (int i = 0; i < WORDS; i++) write_word(i, pat(sel, i));
  endtask

  task automatic expect_all(input int sel, input string req);
    for (int i = 0; i < WORDS; i++) expect_word(i, pat(sel, i), req);
    drain();
  endtask

  task automatic power_on();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    count_busy(RC, "R1 power-up recall length");
    check({wel, prl, as_en} == 3'b000, "R1 latches after power-up", {wel, prl, as_en}, 0);
  endtask

  initial begin
    power_on();
    check(fail_pd == 0, "R9 fail idle low", fail_pd, 0);

    // R5: store refused without latches
    pulse(cmd_store);
    stay_idle(4, "R5 store with no latches");
    pulse(cmd_wren);
    check(wel == 1, "R2 wren sets", wel, 1);
    pulse(cmd_store);
    stay_idle(4, "R5 store without prl");
    @(negedge clk); cmd_wren = 1; cmd_wrds = 1;
    @(negedge clk); cmd_wren = 0; cmd_wrds = 0;
    check(wel == 0, "R2 clear wins over set", wel, 0);

    // R4 software recall
    pulse(cmd_recall);
    count_busy(RC, "R4 recall length");
    check(prl == 1, "R4 recall sets prl", prl, 1);

    // R3 writes gated by wel
    pulse(cmd_wren);
    fill(0);
    pulse(cmd_wrds);
    write_word(5, 16'hdead);
    expect_all(0, "R3 readback, dropped write");

    // R5 store with prl but no wel
    pulse(cmd_store);
    stay_idle(4, "R5 store without wel");

    // R6/R7 store with disturbances while busy
    pulse(cmd_wren);
    pulse(cmd_store);
    begin
      int n = 0;
      while (busy && n < 1000) begin
        n++;
        if (n == 2) begin
          check(wr_ready == 0, "R3 ready low while busy", wr_ready, 0);
          cmd_recall = 1; cmd_wren = 1; cmd_auto_en = 1; recall_pin_n = 0;
          wr_valid = 1; wr_addr = 4'd2; wr_data = 16'hbeef;
        end else if (n == 3) begin
          cmd_recall = 0; cmd_wren = 0; cmd_auto_en = 0; wr_valid = 0;
        end
        @(negedge clk);
      end
      check(n == ST, "R6 store length", n, ST);
    end
    check(wel == 0, "R6 store clears wel (R7 wren ignored)", wel, 0);
    check(as_en == 0, "R7 autostore enable ignored while busy", as_en, 0);
    recall_pin_n = 1;
    stay_idle(5, "R7 recall ignored while busy");
    expect_all(0, "R7 host write dropped while busy");

    // R4 pin recall restores stored words; held low fires once
    pulse(cmd_wren);
    fill(1);
    pulse(cmd_wrds);
    @(negedge clk); recall_pin_n = 0;
    @(negedge clk);
    count_busy(RC, "R4 pin recall length");
    stay_idle(20, "R4 held pin recalls once");
    recall_pin_n = 1;
    expect_all(0, "R4 recall copies shadow");

    // R8 autostore
    pulse(cmd_auto_en);
    check(as_en == 1, "R8 auto enable sets", as_en, 1);
    pulse(cmd_wren);
    fill(2);
    @(negedge clk); supply_low = 1;
    @(negedge clk);
    check(fail_pd == 1, "R9 fail follows supply", fail_pd, 1);
    count_busy(ST, "R8 autostore length");
    check(wel == 0, "R8 autostore clears wel", wel, 0);
    stay_idle(5, "R8 no repeat after wel cleared");
    supply_low = 0;
    @(negedge clk); @(negedge clk);
    check(fail_pd == 0, "R9 fail releases", fail_pd, 0);

    // R10 power cycle keeps shadow
    pulse(cmd_wren);
    fill(3);
    power_on();
    check(prl == 0, "R10 prl clear after power cycle", prl, 0);
    expect_all(2, "R10 shadow restored");

    // R9 without autostore armed
    @(negedge clk); supply_low = 1;
    @(negedge clk);
    check(fail_pd == 1 && !busy, "R9 fail without autostore", {fail_pd, busy}, 2'b10);
    supply_low = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule